// File: doc/BRIEF.md
# Dual-Port Address Collision Busy Arbiter

This block sits beside a two-ported memory and watches the chip enable and word address of its left and right ports. When both ports are enabled on the same word, it lets one of them continue and raises busy toward the other. The port that wins is the one whose access was already in place at the previous clock edge. It also produces a gated write strobe for each port, so that the write of the losing port never reaches the array.

A mode input selects how the block behaves. In master mode the block arbitrates itself and drives the two busy outputs. In slave mode it does no arbitration of its own and holds its busy outputs deasserted. The busy inputs then act only as write-inhibit pins, normally fed from a master's busy outputs so that several parts making up one wide word all block the same side.

Top module: `dp_collide_arb`

## Requirements
- R1: A collision exists only while both enables are active (low) and the two addresses are equal. In every other case both busy outputs are high.
- R2: The write requests (active high) have no effect on either busy output. Only enables and addresses take part in arbitration.
- R3: A port is steady when it was enabled at the previous rising clock edge with the same address it presents now. When a collision begins, the steady port wins and the other port sees its busy output driven low in that same cycle.
- R4: The two busy outputs are never low at the same time.
- R5: Each gated write output equals its write request AND NOT that port's effective busy. In master mode the effective busy is the local arbitration result, and the busy input pins are ignored.
- R6: With the mode input low (slave), both busy outputs stay high and no local arbitration is done. A busy input held high allows that port's writes; a busy input held low blocks them all.
- R7: Busy goes high again in the same cycle the addresses stop matching or either enable goes inactive.
- R8: The winner chosen when a collision begins is held for as long as the collision lasts, even if both ports move together to a new common address.
- R9: When both ports begin a matching access in the same cycle, so that neither is steady, the left port wins and the right busy output goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| masterSel | input | 1 | 1 = master (local arbitration), 0 = slave |
| lEnN | input | 1 | Left chip enable, active low |
| lAddr | input | ADDR_W | Left word address |
| lWrReq | input | 1 | Left write request, active high |
| lBusyInN | input | 1 | Left busy input (slave mode), active low |
| rEnN | input | 1 | Right chip enable, active low |
| rAddr | input | ADDR_W | Right word address |
| rWrReq | input | 1 | Right write request, active high |
| rBusyInN | input | 1 | Right busy input (slave mode), active low |
| lBusyOutN | output | 1 | Left busy output, active low |
| rBusyOutN | output | 1 | Right busy output, active low |
| lWrGated | output | 1 | Left write strobe after inhibit |
| rWrGated | output | 1 | Right write strobe after inhibit |

## Verification
The hardest case to reach is a collision that continues while both ports change address together. The pick made at the start of the collision must survive a cycle in which neither port is steady. The stimulus first builds a collision in which the right port wins. In the next cycle it moves both addresses to one new common word. A design that decided again at that point would apply the tie-break and flip busy to the right port. The held winner keeps busy on the left port. A second sequence starts both ports from idle in the same cycle, which checks the tie-break on its own.

// File: rtl/dp_arb_pkg.sv
package dp_arb_pkg;
  // comparison status from the datapath to the control
  typedef struct packed {
    logic hit;      // both enabled, same word
    logic hitRise;  // collision starts this cycle
    logic lSteady;  // left unchanged since last edge
    logic rSteady;  // right unchanged since last edge
  } cmpStatT;

  // strobes from control to the datapath
  typedef struct packed {
    logic holdL;    // local busy toward left
    logic holdR;    // local busy toward right
  } gateStrobeT;
endpackage

// File: rtl/dp_arb_path.sv
module dp_arb_path
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              masterSel,
  input  logic              lEnN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWrReq,
  input  logic              lBusyInN,
  input  logic              rEnN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWrReq,
  input  logic              rBusyInN,
  input  gateStrobeT        strobe,
  output cmpStatT           stat,
  output logic              lBusyOutN,
  output logic              rBusyOutN,
  output logic              lWrGated,
  output logic              rWrGated
);
  logic              lOn, rOn;
  logic              lOnPrev, rOnPrev, hitPrev;
  logic [ADDR_W-1:0] lAddrPrev, rAddrPrev;
  logic              effBusyL, effBusyR;

  assign lOn = ~lEnN;
  assign rOn = ~rEnN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lOnPrev   <= 1'b0;
      rOnPrev   <= 1'b0;
      hitPrev   <= 1'b0;
      lAddrPrev <= '0;
      rAddrPrev <= '0;
    end else begin
      lOnPrev   <= lOn;
      rOnPrev   <= rOn;
      hitPrev   <= stat.hit;
      lAddrPrev <= lAddr;
      rAddrPrev <= rAddr;
    end
  end

  always_comb begin
    stat.hit     = lOn & rOn & (lAddr == rAddr);
    stat.hitRise = stat.hit & ~hitPrev;
    stat.lSteady = lOn & lOnPrev & (lAddr == lAddrPrev);
    stat.rSteady = rOn & rOnPrev & (rAddr == rAddrPrev);
  end

  // effective busy: local result in master mode, pin in slave mode
  assign effBusyL  = masterSel ? strobe.holdL : ~lBusyInN;
  assign effBusyR  = masterSel ? strobe.holdR : ~rBusyInN;
  assign lBusyOutN = ~(masterSel & strobe.holdL);
  assign rBusyOutN = ~(masterSel & strobe.holdR);
  assign lWrGated  = lWrReq & ~effBusyL;
  assign rWrGated  = rWrReq & ~effBusyR;
endmodule

// File: rtl/dp_arb_ctrl.sv
module dp_arb_ctrl
  import dp_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       masterSel,
  input  cmpStatT    stat,
  output gateStrobeT strobe
);
  logic winR;     // held winner: 1 = right port owns the word
  logic pickR;

  // at collision start the steady side wins; otherwise left wins the tie
  always_comb begin
    if (stat.hitRise) pickR = stat.rSteady & ~stat.lSteady;
    else              pickR = winR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        winR <= 1'b0;
    else if (stat.hit) winR <= pickR;
    else               winR <= 1'b0;
  end

  always_comb begin
    strobe.holdL = masterSel & stat.hit & pickR;
    strobe.holdR = masterSel & stat.hit & ~pickR;
  end
endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              masterSel,
  input  logic              lEnN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWrReq,
  input  logic              lBusyInN,
  input  logic              rEnN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWrReq,
  input  logic              rBusyInN,
  output logic              lBusyOutN,
  output logic              rBusyOutN,
  output logic              lWrGated,
  output logic              rWrGated
);
  cmpStatT    stat;
  gateStrobeT strobe;

  dp_arb_path #(.ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rst_n(rst_n), .masterSel(masterSel),
    .lEnN(lEnN), .lAddr(lAddr), .lWrReq(lWrReq), .lBusyInN(lBusyInN),
    .rEnN(rEnN), .rAddr(rAddr), .rWrReq(rWrReq), .rBusyInN(rBusyInN),
    .strobe(strobe), .stat(stat),
    .lBusyOutN(lBusyOutN), .rBusyOutN(rBusyOutN),
    .lWrGated(lWrGated), .rWrGated(rWrGated)
  );

  dp_arb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .masterSel(masterSel),
    .stat(stat), .strobe(strobe)
  );
endmodule

// File: rtl/dp_collide_arb_chk.sv
module dp_collide_arb_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              masterSel,
  input logic              lEnN,
  input logic [ADDR_W-1:0] lAddr,
  input logic              lWrReq,
  input logic              lBusyInN,
  input logic              rEnN,
  input logic [ADDR_W-1:0] rAddr,
  input logic              rWrReq,
  input logic              rBusyInN,
  input logic              lBusyOutN,
  input logic              rBusyOutN,
  input logic              lWrGated,
  input logic              rWrGated
);
  logic match;
  assign match = !lEnN && !rEnN && (lAddr == rAddr);

  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lBusyOutN && !rBusyOutN)); // R4

  AST_NO_MATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !match |-> (lBusyOutN && rBusyOutN)); // R1

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !masterSel |-> (lBusyOutN && rBusyOutN)); // R6

  AST_LEFT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    lWrGated |-> (lWrReq && (masterSel ? lBusyOutN : lBusyInN))); // R5

  AST_RIGHT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    rWrGated |-> (rWrReq && (masterSel ? rBusyOutN : rBusyInN))); // R5

  AST_WINNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (masterSel && match && $past(masterSel && match && !lBusyOutN)) |-> !lBusyOutN); // R8

  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (masterSel && match && $past(lEnN && rEnN)) |-> !rBusyOutN); // R9
endmodule

bind dp_collide_arb dp_collide_arb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dp_collide_arb_bench.sv
module dp_collide_arb_bench;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          masterSel = 1'b1;
  logic          lEnN = 1'b1, rEnN = 1'b1;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic          lWrReq = 1'b0, rWrReq = 1'b0;
  logic          lBusyInN = 1'b1, rBusyInN = 1'b1;
  logic          lBusyOutN, rBusyOutN, lWrGated, rWrGated;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dp_collide_arb #(.ADDR_W(AW)) u_dp_collide_arb (
    .clk(clk), .rst_n(rst_n), .masterSel(masterSel),
    .lEnN(lEnN), .lAddr(lAddr), .lWrReq(lWrReq), .lBusyInN(lBusyInN),
    .rEnN(rEnN), .rAddr(rAddr), .rWrReq(rWrReq), .rBusyInN(rBusyInN),
    .lBusyOutN(lBusyOutN), .rBusyOutN(rBusyOutN),
    .lWrGated(lWrGated), .rWrGated(rWrGated)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // apply inputs after the falling edge, sample before the next rising edge
  task automatic apply(input logic le, input int la, input logic re, input int ra);
    @(negedge clk);
    lEnN = le; lAddr = AW'(la); rEnN = re; rAddr = AW'(ra);
    #2;
  endtask

  task automatic idle();
    lWrReq = 0; rWrReq = 0; lBusyInN = 1; rBusyInN = 1; masterSel = 1;
    apply(1, 0, 1, 0);
  endtask

  task automatic t_reset();
    chk("R1", "reset lBusy", lBusyOutN, 1'b1);
    chk("R1", "reset rBusy", rBusyOutN, 1'b1);
    chk("R5", "reset lWr", lWrGated, 1'b0);
  endtask

  task automatic t_no_collision();
    idle();
    apply(0, 3, 0, 4);
    chk("R1", "diff addr lBusy", lBusyOutN, 1'b1);
    chk("R1", "diff addr rBusy", rBusyOutN, 1'b1);
    apply(0, 4, 1, 4);
    chk("R1", "right off rBusy", rBusyOutN, 1'b1);
    chk("R1", "right off lBusy", lBusyOutN, 1'b1);
  endtask

  task automatic t_left_first();
    idle();
    apply(0, 5, 1, 0);
    apply(0, 5, 0, 5);
    chk("R3", "left first rBusy", rBusyOutN, 1'b0);
    chk("R3", "left first lBusy", lBusyOutN, 1'b1);
    @(negedge clk); lWrReq = 1; rWrReq = 1; #2;
    chk("R2", "wr req rBusy", rBusyOutN, 1'b0);
    chk("R2", "wr req lBusy", lBusyOutN, 1'b1);
    chk("R5", "winner write", lWrGated, 1'b1);
    chk("R5", "loser write", rWrGated, 1'b0);
    apply(0, 5, 0, 6);
    chk("R7", "addr split rBusy", rBusyOutN, 1'b1);
    chk("R7", "addr split rWr", rWrGated, 1'b1);
    apply(0, 6, 0, 6);
    apply(1, 6, 0, 6);
    chk("R7", "left off rBusy", rBusyOutN, 1'b1);
    chk("R7", "left off lBusy", lBusyOutN, 1'b1);
  endtask

  task automatic t_right_first_hold();
    idle();
    apply(1, 0, 0, 7);
    apply(0, 7, 0, 7);
    chk("R3", "right first lBusy", lBusyOutN, 1'b0);
    chk("R4", "right first rBusy", rBusyOutN, 1'b1);
    apply(0, 9, 0, 9);
    chk("R8", "held lBusy", lBusyOutN, 1'b0);
    chk("R8", "held rBusy", rBusyOutN, 1'b1);
  endtask

  task automatic t_tie();
    idle();
    apply(0, 11, 0, 11);
    chk("R9", "tie rBusy", rBusyOutN, 1'b0);
    chk("R9", "tie lBusy", lBusyOutN, 1'b1);
  endtask

  task automatic t_master_pins_ignored();
    idle();
    @(negedge clk); lBusyInN = 0; rBusyInN = 0; lWrReq = 1; rWrReq = 1; #2;
    chk("R5", "master ignores lBusyIn", lWrGated, 1'b1);
    chk("R5", "master ignores rBusyIn", rWrGated, 1'b1);
  endtask

  task automatic t_slave();
    idle();
    @(negedge clk); masterSel = 0; lWrReq = 1; rWrReq = 1; #2;
    apply(0, 2, 1, 0);
    apply(0, 2, 0, 2);
    chk("R6", "slave lBusy", lBusyOutN, 1'b1);
    chk("R6", "slave rBusy", rBusyOutN, 1'b1);
    chk("R6", "slave pin high lWr", lWrGated, 1'b1);
    chk("R6", "slave pin high rWr", rWrGated, 1'b1);
    @(negedge clk); lBusyInN = 0; #2;
    chk("R6", "slave pin low lWr", lWrGated, 1'b0);
    chk("R6", "slave other rWr", rWrGated, 1'b1);
    @(negedge clk); lBusyInN = 1; rBusyInN = 0; #2;
    chk("R6", "slave pin low rWr", rWrGated, 1'b0);
    chk("R6", "slave release lWr", lWrGated, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    t_reset();
    t_no_collision();
    t_left_first();
    t_right_first_hold();
    t_tie();
    t_master_pins_ignored();
    t_slave();
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule